// File: doc/BRIEF.md
# Atomic Memory Operation Execution Unit

The unit sits beside the storage array of a memory-side target. For each atomic request it receives a 6-bit opcode, a size code, the word currently held in memory and the outbound operand data. From these it works out the word to write back, the value to return to the requester, and three flags. The flags say whether a write must happen, whether a read response carrying data is owed, and whether the request was malformed. The memory access ordering, the bus channel handshakes and the exclusive-access tracking belong to the surrounding target, not to this unit.

The opcode has three fields. Bits [5:4] give the class, bit 3 gives the byte order and bits [2:0] give the operation. An exchange class covers unconditional swap and compare-and-swap. The load and store classes run a read-modify-write with one of eight operations: add, bit clear, exclusive-or, bit set, and signed or unsigned maximum and minimum. The size code is log2 of the byte count. Only the low bytes chosen by the size take part, and all higher bytes of the memory word are carried through unchanged. The result is registered and appears one cycle after the request.

Top module: `atop_unit`

## Requirements
- R1: out_valid is in_valid delayed by one clock. The results of a request are present in the cycle when out_valid is high. Reset drives every output to zero. out_write, out_need_rdata and out_error are zero in any cycle when out_valid is low.
- R2: Opcode 6'b110000 is a swap. The low 2^size bytes of the operand replace the same bytes of the memory word, out_write is 1 and out_need_rdata is 1. Sizes 0 to 3 (1 to 8 bytes) are valid.
- R3: Opcode 6'b110001 is compare-and-swap, with size giving the byte count n = 2^size of each value. Operand bytes [0,n) hold the compare value and bytes [n,2n) hold the swap value. When memory bytes [0,n) equal the compare value, the swap value is written with out_write = 1. Otherwise out_write = 0 and out_new equals the old word. out_need_rdata is 1 in both cases.
- R4: Bits [5:4] of the opcode choose the class: 00 no atomic, 01 store (writes, no data returned), 10 load (writes, returns data), 11 exchange. For any accepted request, out_need_rdata equals opcode bit 5. Load and store requests always set out_write.
- R5: Operation code 000 adds the operand to memory (the carry out of the top byte is dropped). 001 clears each memory bit whose operand bit is set. 010 is exclusive-or. 011 sets each memory bit whose operand bit is set.
- R6: Code 100 keeps the larger and 101 the smaller of the memory and operand values, with both read as two's complement numbers of 8*2^size bits. Codes 110 and 111 do the same with both read as unsigned.
- R7: out_new keeps the old memory contents in every byte at or above 2^size. out_ret holds the old memory bytes [0,2^size) when out_need_rdata is 1, and out_ret is zero in all other bytes and in all other cases.
- R8: In the load and store classes, opcode bit 3 = 1 selects big-endian order for add, max and min. The byte with the lowest address is then the most significant byte within the size. Bit 3 = 0 selects little-endian. Bit 3 has no effect on clear, exclusive-or and set.
- R9: out_error is 1, and out_write and out_need_rdata are 0, in three cases: an exchange-class opcode other than 6'b110000 and 6'b110001; a load, store or swap with size code above 3; or a compare-and-swap whose size code exceeds log2(WORD_BYTES) or 4. In these cases out_new equals the old word and out_ret is zero.
- R10: Class 00 (no atomic) gives out_write = 0, out_need_rdata = 0 and out_error = 0, with out_new equal to the old word and out_ret zero, whatever the other opcode bits and the size are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| in_opcode | input | 6 | Atomic opcode: class, byte order, operation |
| in_size | input | 3 | log2 of the operation byte count |
| in_mem_old | input | 8*WORD_BYTES | Current memory word |
| in_operand | input | 16*WORD_BYTES | Outbound data; compare value at bytes [0,n) and swap value at bytes [n,2n) |
| out_valid | output | 1 | Registered results are valid |
| out_new | output | 8*WORD_BYTES | Word to write back |
| out_ret | output | 8*WORD_BYTES | Value to return to the requester |
| out_need_rdata | output | 1 | A read response with data is owed |
| out_write | output | 1 | The memory word must be written |
| out_error | output | 1 | Malformed opcode or size |

## Verification
The assertions assume that in_opcode, in_size and the data inputs hold known values in every cycle where in_valid is high, and that in_valid is low while reset is asserted. They also assume WORD_BYTES is at least 8, so that the arithmetic lane fits inside the word. The stimulus always drives fully defined values, holds in_valid low during reset, and keeps the default word width. Random requests mostly use sizes 0 to 3. A small share use the reserved exchange opcodes or oversize codes, so that the error path is reached without crowding out the valid operations.

// File: rtl/atop_pkg.sv
package atop_pkg;

  typedef enum logic [1:0] {
    CL_NONE  = 2'b00,
    CL_STORE = 2'b01,
    CL_LOAD  = 2'b10,
    CL_XCHG  = 2'b11
  } op_class_e;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_CLR  = 3'd1,
    OP_EOR  = 3'd2,
    OP_SET  = 3'd3,
    OP_SMAX = 3'd4,
    OP_SMIN = 3'd5,
    OP_UMAX = 3'd6,
    OP_UMIN = 3'd7
  } alu_op_e;

  localparam int unsigned LANE_BYTES = 8;
  localparam int unsigned LANE_W     = 8 * LANE_BYTES;

  typedef logic [LANE_W-1:0] lane_t;

  // Byte enable pattern of a 2^sz-byte lane
  function automatic lane_t lane_mask(logic [1:0] sz);
    lane_t m;
    m = '0;
    for (int i = 0; i < int'(LANE_BYTES); i++) begin
      if (i < (1 << sz)) m[8*i +: 8] = 8'hFF;
    end
    return m;
  endfunction

  // Mirror the low 2^sz bytes; bytes above are zero
  function automatic lane_t byte_rev(lane_t x, logic [1:0] sz);
    lane_t r;
    int n;
    r = '0;
    n = 1 << sz;
    for (int i = 0; i < int'(LANE_BYTES); i++) begin
      if (i < n) r[8*i +: 8] = x[8*(n-1-i) +: 8];
    end
    return r;
  endfunction

  // Sign extension from the top bit of the 2^sz-byte lane
  function automatic lane_t sext(lane_t x, logic [1:0] sz);
    case (sz)
      2'd0:    return {{56{x[7]}},  x[7:0]};
      2'd1:    return {{48{x[15]}}, x[15:0]};
      2'd2:    return {{32{x[31]}}, x[31:0]};
      default: return x;
    endcase
  endfunction

  function automatic logic op_is_arith(alu_op_e op);
    return !(op == OP_CLR || op == OP_EOR || op == OP_SET);
  endfunction

  // Read-modify-write operation; a = memory, b = operand
  function automatic lane_t lane_op(alu_op_e op, lane_t a, lane_t b, logic [1:0] sz);
    lane_t m, ua, ub, sa, sb;
    m  = lane_mask(sz);
    ua = a & m;
    ub = b & m;
    sa = sext(a, sz);
    sb = sext(b, sz);
    case (op)
      OP_ADD:  return a + b;
      OP_CLR:  return a & ~b;
      OP_EOR:  return a ^ b;
      OP_SET:  return a | b;
      OP_SMAX: return ($signed(sa) >= $signed(sb)) ? a : b;
      OP_SMIN: return ($signed(sa) <= $signed(sb)) ? a : b;
      OP_UMAX: return (ua >= ub) ? a : b;
      default: return (ua <= ub) ? a : b;
    endcase
  endfunction

endpackage

// File: rtl/atop_decode.sv
module atop_decode
  import atop_pkg::*;
#(
  parameter int unsigned SWAP_MAX = 3,
  parameter int unsigned CAS_MAX  = 3
) (
  input  logic [5:0] opcode,
  input  logic [2:0] size,
  output op_class_e  cls,
  output alu_op_e    op,
  output logic       rev_en,
  output logic       is_swap,
  output logic       is_cas,
  output logic       is_lane,
  output logic       has_rdata,
  output logic       err
);

  logic xchg, lane_cls, reserved, size_bad;

  always_comb begin
    cls      = op_class_e'(opcode[5:4]);
    op       = alu_op_e'(opcode[2:0]);
    xchg     = (cls == CL_XCHG);
    lane_cls = (cls == CL_STORE) || (cls == CL_LOAD);
    reserved = xchg && (opcode[3:1] != 3'd0);
    if (lane_cls)
      size_bad = (32'(size) > 32'd3);
    else if (xchg)
      size_bad = opcode[0] ? (32'(size) > CAS_MAX) : (32'(size) > SWAP_MAX);
    else
      size_bad = 1'b0;
    err       = reserved || size_bad;
    is_swap   = xchg && !err && !opcode[0];
    is_cas    = xchg && !err && opcode[0];
    is_lane   = lane_cls && !err;
    rev_en    = is_lane && opcode[3] && op_is_arith(op);
    has_rdata = opcode[5] && !err;
  end

endmodule

// File: rtl/atop_lane_alu.sv
module atop_lane_alu
  import atop_pkg::*;
(
  input  alu_op_e    op,
  input  logic       rev_en,
  input  logic [1:0] sz,
  input  lane_t      mem_lane,
  input  lane_t      opnd_lane,
  output lane_t      res_lane
);

  lane_t a_in, b_in, raw;

  always_comb begin
    a_in     = rev_en ? byte_rev(mem_lane, sz)  : mem_lane;
    b_in     = rev_en ? byte_rev(opnd_lane, sz) : opnd_lane;
    raw      = lane_op(op, a_in, b_in, sz) & lane_mask(sz);
    res_lane = rev_en ? byte_rev(raw, sz) : raw;
  end

endmodule

// File: rtl/atop_cas.sv
module atop_cas #(
  parameter int unsigned WORD_BYTES = 8,
  localparam int unsigned W = 8 * WORD_BYTES
) (
  input  logic [2:0]   size,
  input  logic [W-1:0] mem_word,
  input  logic [2*W-1:0] operand,
  output logic [W-1:0] word_mask,
  output logic [W-1:0] swap_val,
  output logic         match
);

  int n;

  always_comb begin
    n         = 1 << size;
    word_mask = '0;
    swap_val  = '0;
    for (int i = 0; i < int'(WORD_BYTES); i++) begin
      if (i < n) begin
        word_mask[8*i +: 8] = 8'hFF;
        swap_val[8*i +: 8]  = operand[8*(i+n) +: 8];
      end
    end
    match = (((mem_word ^ operand[W-1:0]) & word_mask) == '0);
  end

endmodule

// File: rtl/atop_unit.sv
module atop_unit
  import atop_pkg::*;
#(
  parameter int unsigned WORD_BYTES = 8,
  localparam int unsigned W  = 8 * WORD_BYTES,
  localparam int unsigned LG = $clog2(WORD_BYTES),
  localparam int unsigned SWAP_MAX = (LG < 3) ? LG : 3,
  localparam int unsigned CAS_MAX  = (LG < 4) ? LG : 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [5:0]     in_opcode,
  input  logic [2:0]     in_size,
  input  logic [W-1:0]   in_mem_old,
  input  logic [2*W-1:0] in_operand,
  output logic           out_valid,
  output logic [W-1:0]   out_new,
  output logic [W-1:0]   out_ret,
  output logic           out_need_rdata,
  output logic           out_write,
  output logic           out_error
);

  op_class_e w_cls;
  alu_op_e   w_op;
  logic      w_rev, w_is_swap, w_is_cas, w_is_lane, w_has_rdata, w_err;
  logic      w_match;
  logic [W-1:0] w_mask, w_swap_val, w_new, w_ret;
  lane_t     w_lane_res, w_lane_mask;
  logic      w_write;

  atop_decode #(.SWAP_MAX(SWAP_MAX), .CAS_MAX(CAS_MAX)) u_dec (
    .opcode    (in_opcode),
    .size      (in_size),
    .cls       (w_cls),
    .op        (w_op),
    .rev_en    (w_rev),
    .is_swap   (w_is_swap),
    .is_cas    (w_is_cas),
    .is_lane   (w_is_lane),
    .has_rdata (w_has_rdata),
    .err       (w_err)
  );

  atop_lane_alu u_alu (
    .op        (w_op),
    .rev_en    (w_rev),
    .sz        (in_size[1:0]),
    .mem_lane  (in_mem_old[LANE_W-1:0]),
    .opnd_lane (in_operand[LANE_W-1:0]),
    .res_lane  (w_lane_res)
  );

  atop_cas #(.WORD_BYTES(WORD_BYTES)) u_cas (
    .size      (in_size),
    .mem_word  (in_mem_old),
    .operand   (in_operand),
    .word_mask (w_mask),
    .swap_val  (w_swap_val),
    .match     (w_match)
  );

  always_comb begin
    w_lane_mask = lane_mask(in_size[1:0]);
    w_new = in_mem_old;
    if (w_is_lane)
      w_new[LANE_W-1:0] = w_lane_res | (in_mem_old[LANE_W-1:0] & ~w_lane_mask);
    else if (w_is_swap || (w_is_cas && w_match))
      w_new = ((w_is_swap ? in_operand[W-1:0] : w_swap_val) & w_mask) | (in_mem_old & ~w_mask);
    w_write = w_is_lane || w_is_swap || (w_is_cas && w_match);
    w_ret   = w_has_rdata ? (in_mem_old & w_mask) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_new        <= '0;
      out_ret        <= '0;
      out_need_rdata <= 1'b0;
      out_write      <= 1'b0;
      out_error      <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      out_need_rdata <= in_valid && w_has_rdata;
      out_write      <= in_valid && w_write;
      out_error      <= in_valid && w_err;
      if (in_valid) begin
        out_new <= w_new;
        out_ret <= w_ret;
      end
    end
  end

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!out_write && !out_need_rdata && !out_error));
  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_error |-> (!out_write && !out_need_rdata));
  // R7
  upper_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !w_err) |=> (((out_new ^ $past(in_mem_old)) & ~$past(w_mask)) == '0));
  // R4
  rdata_bit5_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_need_rdata |-> $past(in_opcode[5]));
  // R3
  cas_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && w_is_cas && !w_match) |=> (!out_write && out_new == $past(in_mem_old)));
  // R10
  none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_opcode[5:4] == 2'b00) |=> (!out_write && !out_need_rdata && !out_error));
  // R9
  kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> $onehot0({w_is_swap, w_is_cas, w_is_lane, w_err}));

endmodule

// File: tb/sim_atop_unit.sv
module sim_atop_unit;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [5:0]   in_opcode = '0;
  logic [2:0]   in_size = '0;
  logic [63:0]  in_mem_old = '0;
  logic [127:0] in_operand = '0;
  logic         out_valid, out_need_rdata, out_write, out_error;
  logic [63:0]  out_new, out_ret;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atop_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
    .in_size(in_size), .in_mem_old(in_mem_old), .in_operand(in_operand),
    .out_valid(out_valid), .out_new(out_new), .out_ret(out_ret),
    .out_need_rdata(out_need_rdata), .out_write(out_write), .out_error(out_error)
  );

  // Independent behavioural model, byte by byte
  function automatic void model(input logic [5:0] opc, input logic [2:0] sz,
                                input logic [63:0] old, input logic [127:0] opd,
                                output logic [63:0] e_new, output logic [63:0] e_ret,
                                output logic e_rd, output logic e_wr, output logic e_err);
    int n, sh, pos;
    logic be, eq;
    logic [63:0] av, bv, ua, ub, r;
    longint sa, sb;
    n = 1 << sz;
    e_new = old; e_ret = '0; e_rd = 0; e_wr = 0; e_err = 0;
    if (opc[5:4] == 2'b00) return;
    if (opc[5:4] == 2'b11 && opc[3:0] > 4'd1) e_err = 1;
    if (sz > 3'd3) e_err = 1;
    if (e_err) return;
    if (opc[5:4] == 2'b11 && !opc[0]) begin
      for (int i = 0; i < n; i++) e_new[8*i +: 8] = opd[8*i +: 8];
      e_wr = 1; e_rd = 1;
    end else if (opc[5:4] == 2'b11) begin
      eq = 1;
      for (int i = 0; i < n; i++) if (old[8*i +: 8] != opd[8*i +: 8]) eq = 0;
      if (eq) for (int i = 0; i < n; i++) e_new[8*i +: 8] = opd[8*(n+i) +: 8];
      e_wr = eq; e_rd = 1;
    end else begin
      be = opc[3] && !(opc[2:0] inside {3'd1, 3'd2, 3'd3});
      av = '0; bv = '0;
      for (int i = 0; i < n; i++) begin
        pos = be ? n - 1 - i : i;
        av[8*pos +: 8] = old[8*i +: 8];
        bv[8*pos +: 8] = opd[8*i +: 8];
      end
      sh = 64 - 8 * n;
      ua = (av << sh) >> sh;
      ub = (bv << sh) >> sh;
      sa = longint'(av << sh) >>> sh;
      sb = longint'(bv << sh) >>> sh;
      case (opc[2:0])
        3'd0: r = ua + ub;
        3'd1: r = ua & ~ub;
        3'd2: r = ua ^ ub;
        3'd3: r = ua | ub;
        3'd4: r = (sa > sb) ? ua : ub;
        3'd5: r = (sa < sb) ? ua : ub;
        3'd6: r = (ua > ub) ? ua : ub;
        default: r = (ua < ub) ? ua : ub;
      endcase
      for (int i = 0; i < n; i++) begin
        pos = be ? n - 1 - i : i;
        e_new[8*i +: 8] = r[8*pos +: 8];
      end
      e_wr = 1; e_rd = (opc[5:4] == 2'b10);
    end
    if (e_rd) for (int i = 0; i < n; i++) e_ret[8*i +: 8] = old[8*i +: 8];
  endfunction

  task automatic note(input string tag, input logic ok, input string what);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  // Apply one request and compare all outputs against the model
  task automatic run_vec(input string tag, input logic [5:0] opc, input logic [2:0] sz,
                         input logic [63:0] old, input logic [127:0] opd);
    logic [63:0] e_new, e_ret;
    logic e_rd, e_wr, e_err;
    model(opc, sz, old, opd, e_new, e_ret, e_rd, e_wr, e_err);
    @(negedge clk);
    in_valid = 1; in_opcode = opc; in_size = sz; in_mem_old = old; in_operand = opd;
    @(negedge clk);
    in_valid = 0;
    note(tag, out_valid && out_new == e_new && out_ret == e_ret && out_need_rdata == e_rd &&
              out_write == e_wr && out_error == e_err,
         $sformatf("opc=%h sz=%0d act v=%b new=%h ret=%h rd=%b wr=%b er=%b exp new=%h ret=%h rd=%b wr=%b er=%b",
                   opc, sz, out_valid, out_new, out_ret, out_need_rdata, out_write, out_error,
                   e_new, e_ret, e_rd, e_wr, e_err));
  endtask

  // Directed check with literal expectations
  task automatic direct(input string tag, input logic [5:0] opc, input logic [2:0] sz,
                        input logic [63:0] old, input logic [127:0] opd,
                        input logic [63:0] x_new, input logic x_wr, input logic x_err);
    @(negedge clk);
    in_valid = 1; in_opcode = opc; in_size = sz; in_mem_old = old; in_operand = opd;
    @(negedge clk);
    in_valid = 0;
    note(tag, out_new == x_new && out_write == x_wr && out_error == x_err,
         $sformatf("act new=%h wr=%b er=%b exp new=%h wr=%b er=%b",
                   out_new, out_write, out_error, x_new, x_wr, x_err));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] opc;
    logic [2:0] sz;
    logic [63:0] old;
    logic [127:0] opd;
    string tag;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    note("R1", !out_valid && out_new == 0 && out_ret == 0 && !out_write && !out_need_rdata && !out_error,
         $sformatf("reset act v=%b new=%h wr=%b exp all zero", out_valid, out_new, out_write));
    rst_n = 1;
    @(negedge clk);

    // R5 add with carry dropped at the lane top, R7 upper bytes kept
    direct("R7", 6'h10, 3'd2, 64'h1111_1111_FFFF_FFFF, 128'h1, 64'h1111_1111_0000_0000, 1, 0);
    // R1 out_valid drops one cycle after in_valid
    @(negedge clk);
    note("R1", !out_valid && !out_write, $sformatf("idle act v=%b exp 0", out_valid));
    // R8 big-endian add versus little-endian add
    direct("R8", 6'h28, 3'd1, 64'hAAAA_AAAA_AAAA_FF00, 128'h0100, 64'hAAAA_AAAA_AAAA_0001, 1, 0);
    direct("R8", 6'h20, 3'd1, 64'hAAAA_AAAA_AAAA_FF00, 128'h0100, 64'hAAAA_AAAA_AAAA_0000, 1, 0);
    // R8 byte order has no effect on exclusive-or
    direct("R8", 6'h2A, 3'd2, 64'h0123_4567_89AB_CDEF, 128'hFF00_FF00, 64'h0123_4567_76AB_32EF, 1, 0);
    // R6 signed versus unsigned on one byte
    direct("R6", 6'h14, 3'd0, 64'h0000_0000_0000_0080, 128'h7F, 64'h0000_0000_0000_007F, 1, 0);
    direct("R6", 6'h16, 3'd0, 64'h0000_0000_0000_0080, 128'h7F, 64'h0000_0000_0000_0080, 1, 0);
    // R5 bit clear
    direct("R5", 6'h11, 3'd3, 64'hFFFF_0000_FFFF_0000, 128'h0F0F_0F0F_0F0F_0F0F, 64'hF0F0_0000_F0F0_0000, 1, 0);
    // R2 swap of 2 bytes
    direct("R2", 6'h30, 3'd1, 64'h1122_3344_5566_7788, 128'hBEEF, 64'h1122_3344_5566_BEEF, 1, 0);
    // R3 compare-and-swap hit and miss on 4 bytes
    direct("R3", 6'h31, 3'd2, 64'h9999_9999_CAFE_F00D, {64'h0, 32'h1234_5678, 32'hCAFE_F00D},
           64'h9999_9999_1234_5678, 1, 0);
    direct("R3", 6'h31, 3'd2, 64'h9999_9999_CAFE_F00E, {64'h0, 32'h1234_5678, 32'hCAFE_F00D},
           64'h9999_9999_CAFE_F00E, 0, 0);
    // R9 reserved exchange opcode and oversize store
    direct("R9", 6'h32, 3'd0, 64'h5555, 128'h1, 64'h5555, 0, 1);
    direct("R9", 6'h10, 3'd4, 64'h5555, 128'h1, 64'h5555, 0, 1);
    // R10 class 00 ignored regardless of size
    direct("R10", 6'h0F, 3'd7, 64'h7777, 128'h1, 64'h7777, 0, 0);
    // R4 store returns no data, load does
    run_vec("R4", 6'h13, 3'd3, 64'h0123_4567_89AB_CDEF, 128'hF0);
    run_vec("R4", 6'h23, 3'd3, 64'h0123_4567_89AB_CDEF, 128'hF0);

    for (int k = 0; k < 4000; k++) begin
      opc[5:4] = 2'($urandom % 4);
      if (opc[5:4] == 2'b11)
        opc[3:0] = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 2);
      else
        opc[3:0] = 4'($urandom % 16);
      sz = ($urandom % 8 == 0) ? 3'($urandom % 8) : 3'($urandom % 4);
      old = {$urandom, $urandom};
      opd = {$urandom, $urandom, $urandom, $urandom};
      if ($urandom % 2 == 0) opd[63:0] = old;
      if (opc[5:4] == 2'b00) tag = "R10";
      else if (opc[5:4] == 2'b11 && opc[3:0] > 4'd1) tag = "R9";
      else if (sz > 3'd3) tag = "R9";
      else if (opc == 6'h30) tag = "R2";
      else if (opc == 6'h31) tag = "R3";
      else if (opc[2]) tag = "R6";
      else tag = "R5";
      run_vec(tag, opc, sz, old, opd);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule